// File: doc/BRIEF.md
# Mod-60 BCD Seconds Timer

This block counts seconds from 00 to 59 and then starts over at 00. It advances one step on every rising edge of a slow clock, nominally 1 Hz. Its two outputs drive a pair of common-cathode seven-segment digits directly, with one output for the units digit and one for the tens digit.

The units digit is a 4-bit synchronous binary counter. A synchronous clear at 9 limits it to decimal values. The tens digit is a three-bit state machine built from JK-style flip-flops. Its J and K inputs are formed from the present state and from the units carry, so it moves only when the units digit rolls over.

A single active-low input, sampled on the clock edge, forces both digits to zero and holds them there for as long as it stays low. Each digit has its own BCD-to-segment decoder, and both decoder outputs are registered, so the segment pins change only on clock edges.

Top module: `mod60_seconds_timer`

## Requirements
- R1: On every rising edge at which `clr_n` is 0, both digits become 0, and they stay at 0 for as long as `clr_n` remains 0.
- R2: On every rising edge at which `clr_n` is 1, the displayed count (10 × tens + units) increases by exactly one, except as stated in R5.
- R3: On the edge where the units digit is 9, the units digit goes to 0 and the tens digit advances by one in that same edge.
- R4: The tens digit keeps its value on every counting edge at which the units digit is not 9.
- R5: On the counting edge after the display shows 59, it shows 00.
- R6: Segment outputs are active-high and ordered {g,f,e,d,c,b,a} from bit 6 down to bit 0. The codes for digits 0 through 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R7: After reset, the units output only ever shows a digit from 0 to 9 and the tens output only a digit from 0 to 5. Neither output is ever blank. (The decoders blank all segments for codes 10 to 15, but the counters never produce those codes.)
- R8: A low `clr_n` takes priority over counting, including at 59 and at a units rollover. The edge that sees `clr_n` low yields 00, not the next count.
- R9: The segment outputs are registered. They show the new count right after the rising edge on which the count changes, and they hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; one step per rising edge |
| clr_n | input | 1 | Synchronous active-low clear and hold; 1 enables counting |
| seg_ones | output | 7 | Units digit segments {g,f,e,d,c,b,a}, active-high |
| seg_tens | output | 7 | Tens digit segments {g,f,e,d,c,b,a}, active-high |

## Verification
The count is driven through several patterns. A long held clear shows that the value stays at zero rather than drifting. A first run of ten steps exposes any wrong segment code, one digit at a time. A full sweep through 59 and on past the wrap separates a correct tens carry from one that is too early, too late or missing. Short clear pulses placed exactly at 59 and at a units rollover show that clearing outranks counting, and a restart afterwards shows that counting resumes from 00.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_BLANK = '0;
endpackage

// File: rtl/bcd_seg_decoder.sv
`timescale 1ns/1ps
module bcd_seg_decoder
  import timer_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  output seg_t             seg
);
  // bit order {g,f,e,d,c,b,a}, active-high for common cathode
  always_comb begin
    unique case (bcd)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/ones_counter.sv
`timescale 1ns/1ps
module ones_counter #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         clr_n,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next,
  output logic         carry
);
  // binary counter, truncated by a synchronous clear decoded at LAST
  assign carry = (q == LAST[W-1:0]);

  always_comb begin
    if (!clr_n)     q_next = '0;
    else if (carry) q_next = '0;
    else            q_next = q + 1'b1;
  end

  always_ff @(posedge clk) q <= q_next;
endmodule

// File: rtl/jk_tens_counter.sv
`timescale 1ns/1ps
module jk_tens_counter #(
  parameter int W    = 3,
  parameter int LAST = 5
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] tgt;
  logic [W-1:0] j;
  logic [W-1:0] k;

  // desired state, from which J/K excitation is derived per bit
  always_comb begin
    if (!adv)                    tgt = q;
    else if (q == LAST[W-1:0])   tgt = '0;
    else                         tgt = q + 1'b1;
  end

  assign j = tgt & ~q;
  assign k = ~tgt & q;
  assign q_next = clr_n ? tgt : '0;

  for (genvar i = 0; i < W; i++) begin : g_jk
    always_ff @(posedge clk) begin
      if (!clr_n) q[i] <= 1'b0;
      else begin
        unique case ({j[i], k[i]})
          2'b00: q[i] <= q[i];
          2'b01: q[i] <= 1'b0;
          2'b10: q[i] <= 1'b1;
          2'b11: q[i] <= ~q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/mod60_seconds_timer.sv
`timescale 1ns/1ps
module mod60_seconds_timer
  import timer_pkg::*;
#(
  parameter int ONES_W    = 4,
  parameter int TENS_W    = 3,
  parameter int ONES_LAST = 9,
  parameter int TENS_LAST = 5
) (
  input  logic       clk,
  input  logic       clr_n,
  output logic [6:0] seg_ones,
  output logic [6:0] seg_tens
);
  logic [ONES_W-1:0] ones_q, ones_next;
  logic [TENS_W-1:0] tens_q, tens_next;
  logic              ones_carry;
  logic [BCD_W-1:0]  ones_bcd, tens_bcd;
  seg_t              dec_ones, dec_tens;

  ones_counter #(.W(ONES_W), .LAST(ONES_LAST)) u_ones (
    .clk(clk), .clr_n(clr_n), .q(ones_q), .q_next(ones_next), .carry(ones_carry)
  );

  jk_tens_counter #(.W(TENS_W), .LAST(TENS_LAST)) u_tens (
    .clk(clk), .clr_n(clr_n), .adv(ones_carry), .q(tens_q), .q_next(tens_next)
  );

  always_comb begin
    ones_bcd = '0;
    ones_bcd[ONES_W-1:0] = ones_next;
    tens_bcd = '0;
    tens_bcd[TENS_W-1:0] = tens_next;
  end

  bcd_seg_decoder u_dec_ones (.bcd(ones_bcd), .seg(dec_ones));
  bcd_seg_decoder u_dec_tens (.bcd(tens_bcd), .seg(dec_tens));

  // decode the next state so registered segments line up with the count
  always_ff @(posedge clk) begin
    seg_ones <= dec_ones;
    seg_tens <= dec_tens;
  end
endmodule

// File: rtl/mod60_timer_checker.sv
`timescale 1ns/1ps
module mod60_timer_checker (
  input logic       clk,
  input logic       clr_n,
  input logic [6:0] seg_ones,
  input logic [6:0] seg_tens,
  input logic [3:0] ones_q,
  input logic [2:0] tens_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (ones_q == 4'd0 && tens_q == 3'd0)); // R1
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ones_q != 4'd9) |=> (ones_q == $past(ones_q) + 4'd1 && $stable(tens_q))); // R2
  AST_CARRY: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ones_q == 4'd9 && tens_q != 3'd5) |=> (ones_q == 4'd0 && tens_q == $past(tens_q) + 3'd1)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ones_q == 4'd9 && tens_q == 3'd5) |=> (ones_q == 4'd0 && tens_q == 3'd0)); // R5
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!armed)
    (ones_q <= 4'd9 && tens_q <= 3'd5)); // R7
  AST_NO_BLANK: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (seg_ones != 7'h00 && seg_tens != 7'h00)); // R7
endmodule

bind mod60_seconds_timer mod60_timer_checker u_chk (
  .clk(clk), .clr_n(clr_n), .seg_ones(seg_ones), .seg_tens(seg_tens),
  .ones_q(ones_q), .tens_q(tens_q)
);

// File: tb/mod60_seconds_timer_test.sv
`timescale 1ns/1ps
module mod60_seconds_timer_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [6:0] seg_ones, seg_tens;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         model = 0;
  bit         done = 1'b0;

  mod60_seconds_timer uut (
    .clk(clk), .clr_n(clr_n), .seg_ones(seg_ones), .seg_tens(seg_tens)
  );

  always #2.5 clk = ~clk;

  function automatic logic [6:0] seg_code(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // one clock edge; inputs change and outputs are sampled at the falling edge
  task automatic tick();
    @(posedge clk);
    if (!clr_n) model = 0;
    else        model = (model + 1) % 60;
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    logic [6:0] eo, et;
    eo = seg_code(model % 10);
    et = seg_code(model / 10);
    n_cmp++;
    if (seg_ones !== eo || seg_tens !== et) begin
      n_bad++;
      $display("FAIL %s: got tens=%h ones=%h expected tens=%h ones=%h (count %0d)",
               tag, seg_tens, seg_ones, et, eo, model);
    end
  endtask

  task automatic t_reset_hold();
    clr_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R1 held clear");
    end
    check("R6 zero code");
  endtask

  task automatic t_first_digits();
    clr_n = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick();
      check("R2 R6 R9 units step");
    end
    tick();
    check("R3 units rollover to 10");
  endtask

  task automatic t_full_sweep();
    logic [6:0] prev_t;
    for (int i = 0; i < 55; i++) begin
      prev_t = seg_tens;
      tick();
      check("R2 R7 sweep");
      if (model % 10 != 0) begin
        n_cmp++;
        if (seg_tens !== prev_t) begin
          n_bad++;
          $display("FAIL R4: tens got %h expected %h", seg_tens, prev_t);
        end
      end
    end
  endtask

  task automatic t_priority_at_59();
    while (model != 59) tick();
    check("R5 at 59");
    clr_n = 1'b0;
    tick();
    check("R8 clear beats wrap");
    clr_n = 1'b1;
    while (model != 59) tick();
    tick();
    check("R5 59 to 00");
    while (model != 19) tick();
    clr_n = 1'b0;
    tick();
    check("R8 clear beats rollover");
    clr_n = 1'b1;
    tick();
    check("R2 resume from 00");
  endtask

  task automatic t_stable_between_edges();
    logic [6:0] o;
    o = seg_ones;
    #1;
    n_cmp++;
    if (seg_ones !== o) begin
      n_bad++;
      $display("FAIL R9: ones got %h expected %h", seg_ones, o);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_hold();
    t_first_digits();
    t_full_sweep();
    t_priority_at_59();
    t_stable_between_edges();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule